// File: doc/BRIEF.md
# NAND Flash Command Front End

This block sits on the device side of an 8-bit multiplexed flash bus. It watches chip enable, write enable, the command and address latch strobes and the I/O byte lane. It turns the bytes written on that bus into validated operations for a storage back end. Each accepted write is classed as a command, an address or a data byte. The block gathers the address bytes that each command needs and pairs every setup command with its confirm code. It keeps a busy window after each confirmed program, copy-back or erase, and flags any sequence that breaks the command set's rules.

Decoded operations leave through a single-entry valid/ready slot. The bus is driven by the host and cannot be stalled, so back-pressure cannot reach it. An operation stays in the slot, with all its fields frozen, until `op_ready` is seen high. The slot takes a new operation in any cycle where it is empty or is handing off its current one. A new operation that finds the slot full and not handing off is discarded, and `err` pulses. The `busy` and `err` pins are plain status signals.

Top module: `nand_cmd_frontend`

## Requirements
- R1: A byte counts only on a rising edge of `we_n` while `ce_n` is low. `cle` high marks a command, `ale` high marks an address, and neither marks a data byte. Writes with `ce_n` high are ignored, and data bytes outside a program sequence have no effect.
- R2: Command 00h, 01h or 50h followed by three address bytes produces a READ operation. The bytes are taken in the order column, low row, high row. `op_area` is 0, 1 or 2 for 00h, 01h or 50h, and it is 0 for every other operation.
- R3: The sequence 80h, three address bytes, any number of data bytes, then 10h produces one PROGRAM operation and raises `busy`.
- R4: The sequence 60h, two row bytes (low first), then D0h produces one ERASE operation with column 0 and raises `busy`.
- R5: The sequence 00h, three address bytes, then 8Ah first produces the READ operation and then a COPYBACK operation. The COPYBACK carries the same column and row, and it raises `busy`.
- R6: 90h alone produces READID, and 70h alone produces STATUS.
- R7: `busy` stays high for exactly BUSY_CYCLES clock cycles, counted from the cycle in which the confirm is decoded.
- R8: While `busy` is high, only FFh and 70h are accepted. Any other command byte or address byte pulses `err`, produces no operation and leaves `busy` unchanged.
- R9: Each of the following pulses `err` for one cycle and returns the sequencer to idle: a code outside the command set, a confirm code (10h, 8Ah, D0h) with no matching setup, and a write with both `cle` and `ale` high.
- R10: Each of the following pulses `err` and abandons the sequence with no operation: a command or data byte before the address bytes are complete, and an address byte beyond the expected count.
- R11: FFh in any state produces a RESET operation, drops any partly collected sequence and clears `busy` at once.
- R12: An operation stays valid with its fields unchanged until `op_ready` is high. A new operation that arrives while the slot is full and `op_ready` is low is discarded, and `err` pulses. A handoff and a new load in the same cycle both succeed.
- R13: After reset, `op_valid`, `busy` and `err` are low. `op_code` takes these values: READ=0, PROGRAM=1, COPYBACK=2, ERASE=3, READID=4, STATUS=5, RESET=6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write strobe; the byte is taken on its rising edge |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| io | input | 8 | Bus byte lane |
| op_valid | output | 1 | Decoded operation present |
| op_ready | input | 1 | Back end accepts the operation |
| op_code | output | 3 | Operation kind (see R13) |
| op_area | output | 2 | Read area selector |
| op_col | output | 8 | Column address |
| op_row | output | 16 | Row (page) address |
| busy | output | 1 | Array busy window |
| err | output | 1 | One-cycle pulse on a rejected sequence or a dropped operation |

## Verification
The slot can hand off its held operation in the same cycle that the sequencer produces a new one. The bench provokes this by holding `op_ready` low while a STATUS operation waits in the slot. It then writes 90h and raises `op_ready` exactly one clock after the `we_n` edge, so the handoff and the load fall on the same clock edge. The run passes only if the scoreboard sees STATUS and then READID, in that order, with no `err` pulse. A separate case keeps `op_ready` low through the second write and must see one `err` pulse and only the first operation.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_PROGRAM  = 3'd1,
    OP_COPYBACK = 3'd2,
    OP_ERASE    = 3'd3,
    OP_READID   = 3'd4,
    OP_STATUS   = 3'd5,
    OP_RESET    = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    BT_DATA = 2'd0,
    BT_CMD  = 2'd1,
    BT_ADDR = 2'd2,
    BT_BAD  = 2'd3
  } beat_e;

  typedef enum logic [3:0] {
    CC_READ, CC_PROG, CC_ERASE, CC_ID, CC_STATUS, CC_RESET,
    CC_CONF_PROG, CC_CONF_CB, CC_CONF_ERASE, CC_ILLEGAL
  } cmd_class_e;

  typedef enum logic [1:0] {
    PK_READ  = 2'd0,
    PK_PROG  = 2'd1,
    PK_ERASE = 2'd2
  } pend_e;

  function automatic cmd_class_e classify(input logic [7:0] c);
    case (c)
      8'h00, 8'h01, 8'h50: return CC_READ;
      8'h80:               return CC_PROG;
      8'h60:               return CC_ERASE;
      8'h90:               return CC_ID;
      8'h70:               return CC_STATUS;
      8'hFF:               return CC_RESET;
      8'h10:               return CC_CONF_PROG;
      8'h8A:               return CC_CONF_CB;
      8'hD0:               return CC_CONF_ERASE;
      default:             return CC_ILLEGAL;
    endcase
  endfunction

  function automatic logic [1:0] area_of(input logic [7:0] c);
    case (c)
      8'h01:   return 2'd1;
      8'h50:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/nand_bus_capture.sv
module nand_bus_capture
  import nand_fe_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            cle,
  input  logic            ale,
  input  logic [IO_W-1:0] io,
  output logic            beat_v,
  output beat_e           beat_kind,
  output logic [IO_W-1:0] beat_byte
);

  logic            s_we, prev_we, s_ce, s_cle, s_ale;
  logic [IO_W-1:0] s_io;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_we    <= 1'b1;
      prev_we <= 1'b1;
      s_ce    <= 1'b1;
      s_cle   <= 1'b0;
      s_ale   <= 1'b0;
      s_io    <= '0;
    end else begin
      s_we    <= we_n;
      prev_we <= s_we;
      s_ce    <= ce_n;
      s_cle   <= cle;
      s_ale   <= ale;
      s_io    <= io;
    end
  end

  // rising write strobe seen while the chip is selected
  assign beat_v    = s_we && !prev_we && !s_ce;
  assign beat_byte = s_io;

  always_comb begin
    if (s_cle && s_ale)  beat_kind = BT_BAD;
    else if (s_cle)      beat_kind = BT_CMD;
    else if (s_ale)      beat_kind = BT_ADDR;
    else                 beat_kind = BT_DATA;
  end

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int BUSY_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clear_i,
  output logic busy_o
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain <= '0;
    else if (clear_i)          remain <= '0;
    else if (start_i)          remain <= LOAD;
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R11
  clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !busy_o);

endmodule

// File: rtl/nand_op_slot.sv
module nand_op_slot #(
  parameter int PW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [PW-1:0] data_o,
  output logic          overrun_o
);

  logic take;

  assign take      = !valid_o || ready_i;
  assign overrun_o = load_i && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (take) begin
      valid_o <= load_i;
      if (load_i) data_o <= data_i;
    end
  end

  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_fe_pkg::*;
#(
  parameter int IO_W      = 8,
  parameter int ROW_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat_v,
  input  beat_e                     beat_kind,
  input  logic [IO_W-1:0]           beat_byte,
  input  logic                      busy_i,
  output logic                      emit_o,
  output op_e                       emit_code,
  output logic [1:0]                emit_area,
  output logic [IO_W-1:0]           emit_col,
  output logic [ROW_BYTES*IO_W-1:0] emit_row,
  output logic                      err_o,
  output logic                      start_busy_o,
  output logic                      clear_busy_o
);

  localparam int ROW_W   = ROW_BYTES * IO_W;
  localparam int RD_ADDR = ROW_BYTES + 1;
  localparam int ER_ADDR = ROW_BYTES;
  localparam int CNT_W   = $clog2(RD_ADDR + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_CONF, S_CBWAIT} state_e;

  state_e           state, nx_state;
  pend_e            pend, nx_pend;
  logic [1:0]       area, nx_area;
  logic [CNT_W-1:0] cnt, nx_cnt;
  logic [IO_W-1:0]  col_q, col_nx;
  logic [ROW_W-1:0] row_q, row_nx;
  cmd_class_e       cls;
  logic             fresh;
  int               need, ridx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pend  <= PK_READ;
      area  <= 2'd0;
      cnt   <= '0;
      col_q <= '0;
      row_q <= '0;
    end else begin
      state <= nx_state;
      pend  <= nx_pend;
      area  <= nx_area;
      cnt   <= nx_cnt;
      col_q <= col_nx;
      row_q <= row_nx;
    end
  end

  assign cls   = classify(beat_byte[7:0]);
  assign need  = (pend == PK_ERASE) ? ER_ADDR : RD_ADDR;
  assign ridx  = (pend == PK_ERASE) ? int'(cnt) : int'(cnt) - 1;
  // a command seen while waiting for an optional copy-back confirm starts anew
  assign fresh = (state == S_IDLE) ||
                 (state == S_CBWAIT && beat_kind == BT_CMD && cls != CC_CONF_CB);

  always_comb begin
    nx_state     = state;
    nx_pend      = pend;
    nx_area      = area;
    nx_cnt       = cnt;
    col_nx       = col_q;
    row_nx       = row_q;
    emit_o       = 1'b0;
    emit_code    = OP_READ;
    err_o        = 1'b0;
    start_busy_o = 1'b0;
    clear_busy_o = 1'b0;
    if (beat_v) begin
      if (beat_kind == BT_CMD && cls == CC_RESET) begin
        emit_o       = 1'b1;
        emit_code    = OP_RESET;
        clear_busy_o = 1'b1;
        nx_state     = S_IDLE;
      end else if (busy_i) begin
        if (beat_kind == BT_CMD && cls == CC_STATUS) begin
          emit_o    = 1'b1;
          emit_code = OP_STATUS;
        end else if (beat_kind != BT_DATA) begin
          err_o = 1'b1;
        end
      end else if (beat_kind == BT_BAD) begin
        err_o    = 1'b1;
        nx_state = S_IDLE;
      end else if (fresh) begin
        if (beat_kind == BT_CMD) begin
          nx_cnt = '0;
          case (cls)
            CC_READ: begin
              nx_state = S_ADDR;
              nx_pend  = PK_READ;
              nx_area  = area_of(beat_byte[7:0]);
            end
            CC_PROG: begin
              nx_state = S_ADDR;
              nx_pend  = PK_PROG;
            end
            CC_ERASE: begin
              nx_state = S_ADDR;
              nx_pend  = PK_ERASE;
              col_nx   = '0;
            end
            CC_ID: begin
              emit_o    = 1'b1;
              emit_code = OP_READID;
              nx_state  = S_IDLE;
            end
            CC_STATUS: begin
              emit_o    = 1'b1;
              emit_code = OP_STATUS;
              nx_state  = S_IDLE;
            end
            default: begin
              err_o    = 1'b1;
              nx_state = S_IDLE;
            end
          endcase
        end else if (beat_kind == BT_ADDR) begin
          err_o    = 1'b1;
          nx_state = S_IDLE;
        end
      end else begin
        case (state)
          S_ADDR: begin
            if (beat_kind == BT_ADDR) begin
              if (pend != PK_ERASE && cnt == '0) col_nx = beat_byte;
              for (int g = 0; g < ROW_BYTES; g++) begin
                if (ridx == g) row_nx[g*IO_W +: IO_W] = beat_byte;
              end
              if (int'(cnt) == need - 1) begin
                if (pend == PK_READ) begin
                  emit_o    = 1'b1;
                  emit_code = OP_READ;
                  nx_state  = (area == 2'd0) ? S_CBWAIT : S_IDLE;
                end else begin
                  nx_state = S_CONF;
                end
              end else begin
                nx_cnt = cnt + 1'b1;
              end
            end else begin
              err_o    = 1'b1;
              nx_state = S_IDLE;
            end
          end
          S_CONF: begin
            if (beat_kind == BT_CMD) begin
              nx_state = S_IDLE;
              if (pend == PK_PROG && cls == CC_CONF_PROG) begin
                emit_o       = 1'b1;
                emit_code    = OP_PROGRAM;
                start_busy_o = 1'b1;
              end else if (pend == PK_ERASE && cls == CC_CONF_ERASE) begin
                emit_o       = 1'b1;
                emit_code    = OP_ERASE;
                start_busy_o = 1'b1;
              end else begin
                err_o = 1'b1;
              end
            end else if (beat_kind == BT_ADDR || pend == PK_ERASE) begin
              err_o    = 1'b1;
              nx_state = S_IDLE;
            end
          end
          S_CBWAIT: begin
            if (beat_kind == BT_CMD) begin
              emit_o       = 1'b1;
              emit_code    = OP_COPYBACK;
              start_busy_o = 1'b1;
              nx_state     = S_IDLE;
            end else if (beat_kind == BT_ADDR) begin
              err_o    = 1'b1;
              nx_state = S_IDLE;
            end
          end
          default: nx_state = S_IDLE;
        endcase
      end
    end
  end

  assign emit_area = (emit_code == OP_READ) ? nx_area : 2'd0;
  assign emit_col  = col_nx;
  assign emit_row  = row_nx;

  // R8
  busy_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (state == S_IDLE));

  // R9
  no_err_with_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && emit_o));

endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
  import nand_fe_pkg::*;
#(
  parameter int IO_W        = 8,
  parameter int ROW_BYTES   = 2,
  parameter int BUSY_CYCLES = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_n,
  input  logic                      we_n,
  input  logic                      cle,
  input  logic                      ale,
  input  logic [IO_W-1:0]           io,
  output logic                      op_valid,
  input  logic                      op_ready,
  output logic [2:0]                op_code,
  output logic [1:0]                op_area,
  output logic [IO_W-1:0]           op_col,
  output logic [ROW_BYTES*IO_W-1:0] op_row,
  output logic                      busy,
  output logic                      err
);

  localparam int ROW_W = ROW_BYTES * IO_W;
  localparam int PW    = 3 + 2 + IO_W + ROW_W;

  logic             beat_v;
  beat_e            beat_kind;
  logic [IO_W-1:0]  beat_byte;
  logic             emit, fsm_err, start_busy, clear_busy, overrun;
  op_e              emit_code;
  logic [1:0]       emit_area;
  logic [IO_W-1:0]  emit_col;
  logic [ROW_W-1:0] emit_row;
  logic [PW-1:0]    slot_in, slot_out;

  nand_bus_capture #(.IO_W(IO_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .io(io), .beat_v(beat_v), .beat_kind(beat_kind), .beat_byte(beat_byte)
  );

  nand_cmd_seq #(.IO_W(IO_W), .ROW_BYTES(ROW_BYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .beat_v(beat_v), .beat_kind(beat_kind),
    .beat_byte(beat_byte), .busy_i(busy), .emit_o(emit), .emit_code(emit_code),
    .emit_area(emit_area), .emit_col(emit_col), .emit_row(emit_row),
    .err_o(fsm_err), .start_busy_o(start_busy), .clear_busy_o(clear_busy)
  );

  nand_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_busy), .clear_i(clear_busy),
    .busy_o(busy)
  );

  assign slot_in = {emit_code, emit_area, emit_col, emit_row};

  nand_op_slot #(.PW(PW)) slot_i (
    .clk(clk), .rst_n(rst_n), .load_i(emit), .data_i(slot_in),
    .ready_i(op_ready), .valid_o(op_valid), .data_o(slot_out),
    .overrun_o(overrun)
  );

  assign {op_code, op_area, op_col, op_row} = slot_out;

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= fsm_err || overrun;
  end

endmodule

// File: tb/nand_cmd_frontend_tb.sv
module nand_cmd_frontend_tb_top;

  localparam int BUSY = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0]  io = 8'h00;
  logic        op_ready = 1'b1;
  logic        op_valid, busy, err;
  logic [2:0]  op_code;
  logic [1:0]  op_area;
  logic [7:0]  op_col;
  logic [15:0] op_row;

  always #4 clk = ~clk;

  nand_cmd_frontend #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .io(io), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_area(op_area), .op_col(op_col), .op_row(op_row), .busy(busy), .err(err)
  );

  typedef struct {
    logic [2:0]  code;
    logic [1:0]  area;
    logic [7:0]  col;
    logic [15:0] row;
    bit          has_addr;
    string       req;
  } exp_t;

  exp_t sb[$];
  exp_t e;
  int   tests = 0, fails = 0, err_seen = 0, exp_err = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] code, input logic [1:0] area,
                      input logic [7:0] col, input logic [15:0] row,
                      input bit has_addr, input string req);
    exp_t x;
    x.code = code; x.area = area; x.col = col; x.row = row;
    x.has_addr = has_addr; x.req = req;
    sb.push_back(x);
  endtask

  // kind: 0 data, 1 command, 2 address, 3 both strobes
  task automatic beat(input int kind, input logic [7:0] b,
                      input bit sel = 1'b1, input bit late_ready = 1'b0);
    @(posedge clk); #2;
    ce_n = !sel; cle = (kind == 1 || kind == 3); ale = (kind == 2 || kind == 3);
    io = b; we_n = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    we_n = 1'b1;
    @(posedge clk); #2;
    if (late_ready) op_ready = 1'b1;
    @(posedge clk); #2;
    cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (4) @(posedge clk);
    #2;
    check(sb.size() == 0, req, "pending expected ops", sb.size(), 0);
    check(err_seen == exp_err, req, "err pulses", err_seen, exp_err);
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (err) err_seen++;
      if (op_valid && op_ready) begin
        tests++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R12 unexpected op: actual %0h expected none", op_code);
        end else begin
          e = sb.pop_front();
          if (op_code != e.code || op_area != e.area ||
              (e.has_addr && (op_col != e.col || op_row != e.row))) begin
            fails++;
            $display("FAIL %s op: actual %0h/%0h/%0h/%0h expected %0h/%0h/%0h/%0h",
                     e.req, op_code, op_area, op_col, op_row,
                     e.code, e.area, e.col, e.row);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    check(!op_valid && !busy && !err, "R13", "reset outputs",
          {op_valid, busy, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2 three read areas
    push(3'd0, 2'd0, 8'h12, 16'h5634, 1, "R2");
    beat(1, 8'h00); beat(2, 8'h12); beat(2, 8'h34); beat(2, 8'h56);
    push(3'd0, 2'd1, 8'hA1, 16'hC3B2, 1, "R2");
    beat(1, 8'h01); beat(2, 8'hA1); beat(2, 8'hB2); beat(2, 8'hC3);
    push(3'd0, 2'd2, 8'h05, 16'h0706, 1, "R2");
    beat(1, 8'h50); beat(2, 8'h05); beat(2, 8'h06); beat(2, 8'h07);
    drain("R2");

    // R6 single-byte commands
    push(3'd4, 2'd0, 0, 0, 0, "R6"); beat(1, 8'h90);
    push(3'd5, 2'd0, 0, 0, 0, "R6"); beat(1, 8'h70);
    drain("R6");

    // R1 deselected write and stray data ignored
    beat(1, 8'h90, 1'b0);
    beat(0, 8'h5A);
    drain("R1");
    push(3'd5, 2'd0, 0, 0, 0, "R1"); beat(1, 8'h70);
    drain("R1");

    // R3 program with data phase
    push(3'd1, 2'd0, 8'h20, 16'h4030, 1, "R3");
    beat(1, 8'h80); beat(2, 8'h20); beat(2, 8'h30); beat(2, 8'h40);
    beat(0, 8'hDE); beat(0, 8'hAD); beat(0, 8'hBE);
    beat(1, 8'h10);
    check(busy == 1'b1, "R3", "busy after confirm", busy, 1);
    // R8 busy filtering
    beat(1, 8'h60); exp_err++;
    beat(2, 8'h11); exp_err++;
    push(3'd5, 2'd0, 0, 0, 0, "R8"); beat(1, 8'h70);
    check(busy == 1'b1, "R8", "busy kept", busy, 1);
    drain("R8");
    repeat (BUSY) @(posedge clk);
    #2;
    check(busy == 1'b0, "R3", "busy ends", busy, 0);

    // R4 erase, R7 busy length
    push(3'd3, 2'd0, 8'h00, 16'h2211, 1, "R4");
    beat(1, 8'h60); beat(2, 8'h11); beat(2, 8'h22); beat(1, 8'hD0);
    repeat (BUSY - 8) @(posedge clk);
    #2;
    check(busy == 1'b1, "R7", "busy before window end", busy, 1);
    repeat (10) @(posedge clk);
    #2;
    check(busy == 1'b0, "R7", "busy after window end", busy, 0);
    drain("R4");

    // R5 copy-back, R11 reset clears busy
    push(3'd0, 2'd0, 8'h09, 16'h0708, 1, "R5");
    beat(1, 8'h00); beat(2, 8'h09); beat(2, 8'h08); beat(2, 8'h07);
    push(3'd2, 2'd0, 8'h09, 16'h0708, 1, "R5");
    beat(1, 8'h8A);
    check(busy == 1'b1, "R5", "busy after copy-back", busy, 1);
    push(3'd6, 2'd0, 0, 0, 0, "R11"); beat(1, 8'hFF);
    check(busy == 1'b0, "R11", "busy cleared by reset", busy, 0);
    drain("R5");

    // R9 illegal, orphan confirms, both strobes
    beat(1, 8'h33); exp_err++;
    beat(1, 8'h10); exp_err++;
    beat(1, 8'hD0); exp_err++;
    beat(3, 8'h70); exp_err++;
    drain("R9");

    // R10 address count mismatches
    beat(1, 8'h80); beat(2, 8'h01); beat(2, 8'h02); beat(1, 8'h10); exp_err++;
    beat(1, 8'h60); beat(2, 8'h01); beat(2, 8'h02); beat(2, 8'h03); exp_err++;
    beat(1, 8'hD0); exp_err++;
    beat(1, 8'h00); beat(2, 8'h01); beat(1, 8'h70); exp_err++;
    drain("R10");

    // R11 abort mid-sequence
    push(3'd6, 2'd0, 0, 0, 0, "R11");
    beat(1, 8'h80); beat(2, 8'h44); beat(1, 8'hFF);
    beat(1, 8'h10); exp_err++;
    drain("R11");

    // R12 overrun while held
    op_ready = 1'b0;
    push(3'd5, 2'd0, 0, 0, 0, "R12"); beat(1, 8'h70);
    check(op_valid == 1'b1, "R12", "held valid", op_valid, 1);
    beat(1, 8'h90); exp_err++;
    check(op_code == 3'd5, "R12", "held code stable", op_code, 5);
    op_ready = 1'b1;
    drain("R12");

    // R12 handoff and load on the same edge
    op_ready = 1'b0;
    push(3'd5, 2'd0, 0, 0, 0, "R12"); beat(1, 8'h70);
    push(3'd4, 2'd0, 0, 0, 0, "R12"); beat(1, 8'h90, 1'b1, 1'b1);
    drain("R12");

    done = 1;
    report();
    $finish;
  end

endmodule